// File: doc/BRIEF.md
# Register-Window Trap Entry Sequencer

This block carries out trap entry for a 32-bit processor with rotating register windows. When a take-trap strobe arrives with an 8-bit trap type, it checks the trap-enable bit. If traps are disabled, the block stops in a terminal state: either a shutdown request or an error halt. If traps are enabled, it runs a fixed two-cycle entry. In the first cycle it clears trap enable, moves the supervisor bit into the previous-supervisor bit and sets supervisor, and rotates the window pointer down by one. In the same cycle it puts the trap type into the trap base register and vectors PC and nPC to the handler. In the second cycle it writes the interrupted PC and nPC into locals 1 and 2 of the fresh window, through a single register-file write port that carries two data lanes.

An FP-exception trap gets two extra steps. The PC and nPC pair is stepped forward one instruction before it is saved, so delivery looks deferred. The faulting instruction is also queued, but only if the FP queue is empty. An external-interrupt trap produces a one-cycle acknowledge that carries the trap type. The architectural state can be written through a load port while the sequencer is idle. This stands for the processor's ordinary state writes, including a return from a trap handler.

The controller has five states:
- `S_IDLE`: waiting for a trap.
- `S_ENTER`: the state-update cycle.
- `S_SAVE`: the register-write cycle.
- `S_HALT`: the error halt.
- `S_SHUT`: the shutdown request.

It has these transitions:
- IDLE→ENTER: a trap arrives with trap enable set.
- IDLE→SHUT: a type 0x80 trap arrives with traps disabled and the shutdown option on.
- IDLE→HALT: any other trap arrives with traps disabled.
- ENTER→SAVE: always.
- SAVE→IDLE: always.
- HALT and SHUT: hold until reset.

Top module: `trap_entry_seq`

## Requirements
- R1: With trap_en at 0, a trap of type 0x80 while shutdown_en is 1 raises shutdown_req from the next cycle. Any other disabled trap raises error_halt instead. In both cases no architectural state changes, and the state holds until reset.
- R2: An accepted trap clears trap_en.
- R3: Entry decrements cwp by one, and window 0 wraps to window 7.
- R4: Entry copies the old sup into prev_sup and sets sup to 1.
- R5: On entry, tbr becomes {base[31:12], trap_type, 4'b0000}. PC is loaded from tbr, and nPC becomes PC+4. This applies to hardware types and to software types 0x80–0xFF alike.
- R6: In the cycle after the state update, rf_we is 1. In that cycle rf_win is the new window, rf_l1_data is the interrupted PC, and rf_l2_data is the interrupted nPC.
- R7: For trap type 0x08 (FP exception), the saved PC is the old nPC and the saved nPC is the old nPC+4.
- R8: For trap type 0x08 with fq_valid at 0, entry sets fq_valid, stores the old PC in fq_addr and stores fetch_word in fq_insn. With fq_valid already 1, the queue is left unchanged.
- R9: For trap types 0x11–0x1F, irq_ack is 1 for exactly the write cycle, with irq_ack_tt set to the type. For any other type, including 0x10 and 0x20, irq_ack stays 0.
- R10: busy is 1 for exactly the two cycles after the strobe is accepted. A strobe seen while busy is ignored.
- R11: In IDLE, ld_en without trap_req loads trap_en, sup, prev_sup, cwp, the tbr base, PC and nPC. If ld_fq_clr is set, the same load also clears fq_valid. When trap_req occurs in the same cycle, the trap wins and the load is discarded.
- R12: After reset: trap_en=0, sup=1, prev_sup=0, cwp=0, tbr=0, pc=0, npc=4, fq_valid=0, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take-trap strobe |
| trap_type | input | 8 | Trap type of the strobe |
| shutdown_en | input | 1 | Type 0x80 with traps disabled requests shutdown |
| fetch_word | input | 32 | Instruction word at the current PC |
| ld_en | input | 1 | Load architectural state |
| ld_trap_en | input | 1 | Load value for trap_en |
| ld_sup | input | 1 | Load value for sup |
| ld_prev_sup | input | 1 | Load value for prev_sup |
| ld_cwp | input | 3 | Load value for cwp |
| ld_tbr_base | input | 20 | Load value for the tbr base field |
| ld_pc | input | 32 | Load value for PC |
| ld_npc | input | 32 | Load value for nPC |
| ld_fq_clr | input | 1 | Clear the FP queue with the load |
| busy | output | 1 | Entry in progress |
| trap_en | output | 1 | Trap enable |
| sup | output | 1 | Supervisor bit |
| prev_sup | output | 1 | Previous supervisor bit |
| cwp | output | 3 | Current window pointer |
| tbr | output | 32 | Trap base register |
| pc | output | 32 | Program counter |
| npc | output | 32 | Next program counter |
| rf_we | output | 1 | Register-file write strobe |
| rf_win | output | 3 | Target window of the write |
| rf_l1_data | output | 32 | Data for local 1 (saved PC) |
| rf_l2_data | output | 32 | Data for local 2 (saved nPC) |
| fq_valid | output | 1 | FP queue not empty |
| fq_addr | output | 32 | Queued instruction address |
| fq_insn | output | 32 | Queued instruction word |
| irq_ack | output | 1 | External interrupt acknowledge |
| irq_ack_tt | output | 8 | Type being acknowledged |
| shutdown_req | output | 1 | Shutdown requested |
| error_halt | output | 1 | Error halt |

## Verification
A state load and a trap strobe can fall in the same idle cycle. The bench provokes this by driving ld_en with distinct values together with trap_req. It then judges the outcome from the saved PC, the new window and the vector, all of which must be derived from the state before the load. The FP-queue fill and the delayed PC step also coincide on one trap. So type 0x08 is issued with both an empty and a full queue, and the saved pair and the queue contents are compared with a model.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    localparam int TT_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENTER,
        S_SAVE,
        S_HALT,
        S_SHUT
    } seq_state_t;

    localparam logic [TT_W-1:0] TT_FP_EXC   = 8'h08;
    localparam logic [TT_W-1:0] TT_SHUTDOWN = 8'h80;

    function automatic logic is_ext_irq(input logic [TT_W-1:0] t);
        return (t[7:4] == 4'h1) && (t[3:0] != 4'h0);
    endfunction

endpackage

// File: rtl/trap_win_dec.sv
module trap_win_dec #(
    parameter int NWIN  = 8,
    parameter int CWP_W = 3
) (
    input  logic [CWP_W-1:0] cur,
    output logic [CWP_W-1:0] nxt
);
    localparam bit POW2 = ((1 << CWP_W) == NWIN);

    generate
        if (POW2) begin : g_pow2
            assign nxt = cur - CWP_W'(1);
        end else begin : g_mod
            assign nxt = (cur == '0) ? CWP_W'(NWIN - 1) : cur - CWP_W'(1);
        end
    endgenerate
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
    parameter int XLEN   = 32,
    parameter int BASE_W = 20,
    parameter int TT_W   = 8
) (
    input  logic [BASE_W-1:0] base,
    input  logic [TT_W-1:0]   tt,
    output logic [XLEN-1:0]   vec_pc,
    output logic [XLEN-1:0]   vec_npc
);
    localparam int PAD_W = XLEN - BASE_W - TT_W;

    assign vec_pc  = {base, tt, {PAD_W{1'b0}}};
    assign vec_npc = vec_pc + XLEN'(4);
endmodule

// File: rtl/trap_fq_unit.sv
module trap_fq_unit #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            clr,
    input  logic [XLEN-1:0] cap_addr,
    input  logic [XLEN-1:0] cap_insn,
    output logic            valid,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] insn
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            insn  <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (capture && !valid) begin
            valid <= 1'b1;
            addr  <= cap_addr;
            insn  <= cap_insn;
        end
    end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NWIN   = 8,
    parameter int BASE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [7:0]        trap_type,
    input  logic              shutdown_en,
    input  logic [XLEN-1:0]   fetch_word,
    input  logic              ld_en,
    input  logic              ld_trap_en,
    input  logic              ld_sup,
    input  logic              ld_prev_sup,
    input  logic [2:0]        ld_cwp,
    input  logic [BASE_W-1:0] ld_tbr_base,
    input  logic [XLEN-1:0]   ld_pc,
    input  logic [XLEN-1:0]   ld_npc,
    input  logic              ld_fq_clr,
    output logic              busy,
    output logic              trap_en,
    output logic              sup,
    output logic              prev_sup,
    output logic [2:0]        cwp,
    output logic [XLEN-1:0]   tbr,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   npc,
    output logic              rf_we,
    output logic [2:0]        rf_win,
    output logic [XLEN-1:0]   rf_l1_data,
    output logic [XLEN-1:0]   rf_l2_data,
    output logic              fq_valid,
    output logic [XLEN-1:0]   fq_addr,
    output logic [XLEN-1:0]   fq_insn,
    output logic              irq_ack,
    output logic [7:0]        irq_ack_tt,
    output logic              shutdown_req,
    output logic              error_halt
);
    localparam int CWP_W = $clog2(NWIN);
    localparam int PAD_W = XLEN - BASE_W - TT_W;

    seq_state_t state, state_nxt;

    logic [TT_W-1:0]   tt_q;
    logic [TT_W-1:0]   tbr_tt_q;
    logic [BASE_W-1:0] base_q;
    logic [XLEN-1:0]   saved_pc_q, saved_npc_q;
    logic [CWP_W-1:0]  cwp_q, cwp_dec;
    logic [XLEN-1:0]   vec_pc, vec_npc;
    logic              idle_accept, idle_load, enter_fp;

    // strobe accepted in idle with traps enabled; the trap beats a load
    assign idle_accept = (state == S_IDLE) && trap_req && trap_en;
    assign idle_load   = (state == S_IDLE) && ld_en && !trap_req;
    assign enter_fp    = (state == S_ENTER) && (tt_q == TT_FP_EXC);

    trap_win_dec #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
        .cur (cwp_q),
        .nxt (cwp_dec)
    );

    trap_vec_gen #(.XLEN(XLEN), .BASE_W(BASE_W), .TT_W(TT_W)) u_vec (
        .base    (base_q),
        .tt      (tt_q),
        .vec_pc  (vec_pc),
        .vec_npc (vec_npc)
    );

    trap_fq_unit #(.XLEN(XLEN)) u_fq (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (enter_fp),
        .clr      (idle_load && ld_fq_clr),
        .cap_addr (pc),
        .cap_insn (fetch_word),
        .valid    (fq_valid),
        .addr     (fq_addr),
        .insn     (fq_insn)
    );

    // next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (trap_req) begin
                    if (trap_en)
                        state_nxt = S_ENTER;
                    else if (trap_type == TT_SHUTDOWN && shutdown_en)
                        state_nxt = S_SHUT;
                    else
                        state_nxt = S_HALT;
                end
            end
            S_ENTER: state_nxt = S_SAVE;
            S_SAVE:  state_nxt = S_IDLE;
            S_HALT:  state_nxt = S_HALT;
            S_SHUT:  state_nxt = S_SHUT;
            default: state_nxt = S_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // architectural state updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_en     <= 1'b0;
            sup         <= 1'b1;
            prev_sup    <= 1'b0;
            cwp_q       <= '0;
            base_q      <= '0;
            tbr_tt_q    <= '0;
            pc          <= '0;
            npc         <= XLEN'(4);
            tt_q        <= '0;
            saved_pc_q  <= '0;
            saved_npc_q <= '0;
        end else if (idle_accept) begin
            tt_q <= trap_type;
        end else if (idle_load) begin
            trap_en  <= ld_trap_en;
            sup      <= ld_sup;
            prev_sup <= ld_prev_sup;
            cwp_q    <= CWP_W'(ld_cwp);
            base_q   <= ld_tbr_base;
            pc       <= ld_pc;
            npc      <= ld_npc;
        end else if (state == S_ENTER) begin
            trap_en  <= 1'b0;
            prev_sup <= sup;
            sup      <= 1'b1;
            cwp_q    <= cwp_dec;
            tbr_tt_q <= tt_q;
            pc       <= vec_pc;
            npc      <= vec_npc;
            if (tt_q == TT_FP_EXC) begin
                saved_pc_q  <= npc;
                saved_npc_q <= npc + XLEN'(4);
            end else begin
                saved_pc_q  <= pc;
                saved_npc_q <= npc;
            end
        end
    end

    assign cwp = 3'(cwp_q);
    assign tbr = {base_q, tbr_tt_q, {PAD_W{1'b0}}};

    // outputs decoded from state
    always_comb begin
        busy         = 1'b0;
        rf_we        = 1'b0;
        irq_ack      = 1'b0;
        shutdown_req = 1'b0;
        error_halt   = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_ENTER: busy = 1'b1;
            S_SAVE: begin
                busy    = 1'b1;
                rf_we   = 1'b1;
                irq_ack = is_ext_irq(tt_q);
            end
            S_HALT:  error_halt   = 1'b1;
            S_SHUT:  shutdown_req = 1'b1;
            default: error_halt   = 1'b1;
        endcase
    end

    assign rf_win     = 3'(cwp_q);
    assign rf_l1_data = saved_pc_q;
    assign rf_l2_data = saved_npc_q;
    assign irq_ack_tt = irq_ack ? tt_q : 8'h00;

endmodule

// File: rtl/trap_entry_sva.sv
module trap_entry_sva #(
    parameter int XLEN = 32,
    parameter int NWIN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            rf_we,
    input logic            trap_en,
    input logic            sup,
    input logic [2:0]      cwp,
    input logic [XLEN-1:0] tbr,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] npc,
    input logic            irq_ack,
    input logic            error_halt,
    input logic            shutdown_req
);
    a_r2_et_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !trap_en);

    a_r3_win_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rf_we) |=> (cwp == (($past(cwp) == 3'd0) ? 3'(NWIN - 1) : $past(cwp) - 3'd1)));

    a_r4_sup_set: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> sup);

    a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (pc == tbr && npc == tbr + XLEN'(4) && tbr[3:0] == 4'h0));

    a_r9_ack_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> rf_we);

    a_r10_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !busy);

    a_r10_enter_then_save: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rf_we) |=> rf_we);

    a_r1_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error_halt |=> (error_halt && !busy && !shutdown_req));

    a_r1_shut_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> (shutdown_req && $stable(pc)));
endmodule

bind trap_entry_seq trap_entry_sva #(.XLEN(XLEN), .NWIN(NWIN)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .rf_we        (rf_we),
    .trap_en      (trap_en),
    .sup          (sup),
    .cwp          (cwp),
    .tbr          (tbr),
    .pc           (pc),
    .npc          (npc),
    .irq_ack      (irq_ack),
    .error_halt   (error_halt),
    .shutdown_req (shutdown_req)
);

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        trap_req = 0, shutdown_en = 0, ld_en = 0;
    logic [7:0]  trap_type = 0;
    logic [31:0] fetch_word = 0, ld_pc = 0, ld_npc = 0;
    logic        ld_trap_en = 0, ld_sup = 0, ld_prev_sup = 0, ld_fq_clr = 0;
    logic [2:0]  ld_cwp = 0;
    logic [19:0] ld_tbr_base = 0;
    logic        busy, trap_en, sup, prev_sup, rf_we, fq_valid, irq_ack, shutdown_req, error_halt;
    logic [2:0]  cwp, rf_win;
    logic [31:0] tbr, pc, npc, rf_l1_data, rf_l2_data, fq_addr, fq_insn;
    logic [7:0]  irq_ack_tt;

    trap_entry_seq dut (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // model of the architectural state
    logic        m_sup, m_ps;
    logic [2:0]  m_cwp;
    logic [19:0] m_base;
    logic [31:0] m_pc, m_npc, m_fqa, m_fqi;
    logic        m_fqv;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_vec(input logic [19:0] b, input logic [7:0] t);
        return {b, t, 4'h0};
    endfunction

    function automatic bit f_ext(input logic [7:0] t);
        return (t >= 8'h11) && (t <= 8'h1f);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 0; trap_req = 0; ld_en = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        m_sup = 1; m_ps = 0; m_cwp = 0; m_base = 0; m_pc = 0; m_npc = 4; m_fqv = 0; m_fqa = 0; m_fqi = 0;
    endtask

    task automatic do_load(input logic [2:0] c, input logic [19:0] b, input logic [31:0] p,
                           input logic [31:0] n, input logic s, input logic ps, input logic fclr);
        @(negedge clk);
        ld_en = 1; ld_trap_en = 1; ld_sup = s; ld_prev_sup = ps; ld_cwp = c;
        ld_tbr_base = b; ld_pc = p; ld_npc = n; ld_fq_clr = fclr;
        @(negedge clk); ld_en = 0; ld_fq_clr = 0;
        m_sup = s; m_ps = ps; m_cwp = c; m_base = b; m_pc = p; m_npc = n;
        if (fclr) m_fqv = 0;
        chk(trap_en == 1 && cwp == c && pc == p && npc == n, "R11 load", {29'd0, cwp}, {29'd0, c});
    endtask

    // issues a trap with traps enabled; optionally holds the strobe and drives a rival load
    task automatic do_trap(input logic [7:0] t, input bit hold, input bit rival);
        logic [2:0]  ecwp;
        logic [31:0] esp, esn, ev;
        fetch_word = $urandom;
        @(negedge clk);
        trap_type = t; trap_req = 1;
        if (rival) begin
            ld_en = 1; ld_trap_en = 1; ld_cwp = m_cwp + 3'd3; ld_pc = 32'hdead0000; ld_npc = 32'hdead0004;
            ld_tbr_base = ~m_base;
        end
        @(negedge clk);
        ld_en = 0;
        if (!hold) trap_req = 0;
        chk(busy == 1 && rf_we == 0, "R10 busy enter", {31'd0, busy}, 32'd1);
        ecwp = m_cwp - 3'd1;
        esp = (t == 8'h08) ? m_npc : m_pc;
        esn = (t == 8'h08) ? m_npc + 32'd4 : m_npc;
        ev = f_vec(m_base, t);
        if (t == 8'h08 && !m_fqv) begin m_fqv = 1; m_fqa = m_pc; m_fqi = fetch_word; end
        @(negedge clk);
        chk(trap_en == 0, "R2 trap_en cleared", {31'd0, trap_en}, 32'd0);
        chk(cwp == ecwp && rf_win == ecwp, "R3 window", {29'd0, cwp}, {29'd0, ecwp});
        chk(sup == 1 && prev_sup == m_sup, "R4 sup/prev", {31'd0, prev_sup}, {31'd0, m_sup});
        chk(tbr == ev && pc == ev && npc == ev + 4, "R5 vector", pc, ev);
        chk(rf_we == 1 && busy == 1, "R6 write strobe", {31'd0, rf_we}, 32'd1);
        chk(rf_l1_data == esp, (t == 8'h08) ? "R7 saved pc" : "R6 saved pc", rf_l1_data, esp);
        chk(rf_l2_data == esn, (t == 8'h08) ? "R7 saved npc" : "R6 saved npc", rf_l2_data, esn);
        chk(fq_valid == m_fqv && fq_addr == m_fqa && fq_insn == m_fqi, "R8 fp queue", fq_addr, m_fqa);
        chk(irq_ack == f_ext(t) && irq_ack_tt == (f_ext(t) ? t : 8'h00), "R9 ack", {24'd0, irq_ack_tt},
            {24'd0, f_ext(t) ? t : 8'h00});
        @(negedge clk);
        trap_req = 0;
        chk(busy == 0 && rf_we == 0 && irq_ack == 0, "R10 idle after", {31'd0, busy}, 32'd0);
        if (hold) begin
            @(negedge clk);
            chk(busy == 0 && cwp == ecwp, "R10 strobe while busy ignored", {29'd0, cwp}, {29'd0, ecwp});
        end
        if (rival) chk(pc == ev && cwp == ecwp, "R11 trap beats load", pc, ev);
        m_ps = m_sup; m_sup = 1; m_cwp = ecwp; m_pc = ev; m_npc = ev + 4;
    endtask

    task automatic disabled_trap(input logic [7:0] t, input bit sd, input bit exp_shut);
        do_reset();
        @(negedge clk); trap_type = t; shutdown_en = sd; trap_req = 1;
        @(negedge clk); trap_req = 0;
        chk(shutdown_req == exp_shut && error_halt == !exp_shut, "R1 disabled trap", {31'd0, shutdown_req},
            {31'd0, exp_shut});
        @(negedge clk); trap_req = 1;
        repeat (3) @(negedge clk);
        trap_req = 0;
        chk(shutdown_req == exp_shut && error_halt == !exp_shut && busy == 0 && pc == 0 && cwp == 0 && sup == 1,
            "R1 held, no change", pc, 32'd0);
        shutdown_en = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        @(negedge clk);
        chk(trap_en == 0 && sup == 1 && prev_sup == 0 && cwp == 0 && tbr == 0 && pc == 0 && npc == 4 &&
            fq_valid == 0 && busy == 0 && rf_we == 0 && irq_ack == 0 && error_halt == 0 && shutdown_req == 0,
            "R12 reset state", npc, 32'd4);

        disabled_trap(8'h80, 1, 1);
        disabled_trap(8'h80, 0, 0);
        disabled_trap(8'h05, 1, 0);

        do_reset();
        // directed: wrap from window 0, boundary interrupt codes, software trap
        do_load(3'd0, 20'h12345, 32'h1000, 32'h1004, 0, 1, 1); do_trap(8'h11, 0, 0);
        do_load(3'd4, 20'h00abc, 32'h2000, 32'h2004, 1, 0, 0); do_trap(8'h10, 0, 0);
        do_load(3'd1, 20'hfffff, 32'h3000, 32'h3008, 0, 0, 0); do_trap(8'h1f, 1, 0);
        do_load(3'd7, 20'h00001, 32'h4000, 32'h4004, 1, 1, 0); do_trap(8'h20, 0, 0);
        do_load(3'd2, 20'h55555, 32'h5000, 32'h5004, 0, 0, 0); do_trap(8'hff, 0, 0);
        // FP exception with empty then full queue
        do_load(3'd3, 20'h0f0f0, 32'h6000, 32'h6004, 0, 0, 1); do_trap(8'h08, 0, 0);
        do_load(3'd5, 20'h0f0f0, 32'h7000, 32'h7010, 1, 0, 0); do_trap(8'h08, 0, 0);
        // load and trap in the same cycle
        do_load(3'd6, 20'h3c3c3, 32'h8000, 32'h8004, 0, 1, 0); do_trap(8'h0a, 0, 1);

        for (int i = 0; i < 40; i++) begin
            logic [7:0] t;
            int k = $urandom_range(0, 3);
            t = (k == 0) ? 8'h08 : (k == 1) ? 8'h10 + 8'($urandom_range(0, 16)) :
                (k == 2) ? 8'h80 + 8'($urandom_range(0, 127)) : 8'($urandom_range(1, 127));
            do_load(3'($urandom), 20'($urandom), {$urandom} & 32'hfffffffc, {$urandom} & 32'hfffffffc,
                    1'($urandom), 1'($urandom), 1'($urandom));
            do_trap(t, 1'($urandom), ($urandom_range(0, 4) == 0));
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (100000) @(posedge clk); chk(0, "watchdog", 32'd0, 32'd1); end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule